// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of an eight-channel DMA controller inside a USB device core. A host CPU reaches it through a simple bus that carries a byte address, a write strobe, a read strobe, 32-bit write data with byte enables, and 32-bit read data. Each channel has three registers: a 16-bit control word, a 32-bit transfer address and a 32-bit byte count. One shared status byte holds a completion flag for each channel.

The bank decodes accesses and unpacks the control fields into per-channel configuration outputs. It issues one-cycle start and abort pulses to the channel engines. In the other direction, the engines report completion, bus errors, their live current address and their remaining count. The bank turns completions into status bits and an interrupt request. It keeps bus errors as sticky flags. Reads of the address and count registers return the live values from the engines. Data movement and the endpoint FIFOs belong to the engines and are not part of this block.

Top module: `dma_regbank`

## Requirements
- R1: Register map, with byte offsets. The status byte is at 0x200, in bits 7:0. For channel n, control is at 0x204+16n in bits 15:0, address is at 0x208+16n and count is at 0x20C+16n. Address bits 1:0 are ignored. The read strobe returns its data on `bus_rdata_o` in the next cycle. At all other times `bus_rdata_o` is zero.
- R2: Control fields are: bit 0 enable, bit 1 transmit, bit 2 mode 1, bit 3 interrupt enable, bits 7:4 endpoint, and bits 10:9 burst (0 unspecified, 1 four-beat, 2 eight-beat, 3 sixteen-beat). Byte lane 0 writes bits 7:0 and byte lane 1 writes bits 10:9. The fields drive the `ch_*` outputs. Readback shows bits 15:11 as zero.
- R3: Writes to the address and count registers update only the enabled byte lanes. The stored values appear on `ch_addr_o` and `ch_count_o` after the write edge.
- R4: A control write with lane 0 enabled and bit 0 set raises `ch_start_o[n]` in the cycle after the write, for one cycle.
- R5: A control write with lane 0 enabled and bit 0 clear, to a channel whose enable is set, raises `ch_abort_o[n]` for one cycle and clears enable. Writing zero to address and count returns those outputs to zero.
- R6: `eng_done_i[n]` clears the enable bit of channel n. If a lane-0 control write to the same channel happens in the same cycle, the write wins.
- R7: `eng_bus_err_i[n]` sets control bit 8 of channel n. The bit stays set until a control write with lane 1 enabled, whatever the data. If a new error arrives in the same cycle as that write, the bit stays set. Software cannot set bit 8.
- R8: A read of the address register returns `eng_cur_addr_i` for that channel. A read of the count register returns `eng_rem_count_i` for that channel.
- R9: A read of the status word returns the pending bits and then clears them. A completion that arrives in the same cycle as that read is left pending.
- R10: `irq_o` is high when any status bit n is set and channel n has interrupt enable (control bit 3) set.
- R11: Writes to unmapped offsets and to the status word are ignored. Reads from unmapped offsets return zero. Unmapped offsets are those outside 0x200 to 0x27F and word +0 of channels 1 to 7.
- R12: After reset, every register, pulse, status bit, `irq_o` and `bus_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Write byte enables |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| eng_done_i | input | 8 | Per-channel completion pulse |
| eng_bus_err_i | input | 8 | Per-channel bus error pulse |
| eng_cur_addr_i | input | 256 | Live current address, 32 bits per channel |
| eng_rem_count_i | input | 256 | Live remaining count, 32 bits per channel |
| ch_start_o | output | 8 | Start pulse per channel |
| ch_abort_o | output | 8 | Abort pulse per channel |
| ch_en_o | output | 8 | Enable bit per channel |
| ch_tx_o | output | 8 | Transmit direction per channel |
| ch_mode1_o | output | 8 | Mode 1 select per channel |
| ch_ep_o | output | 32 | Endpoint number, 4 bits per channel |
| ch_burst_o | output | 16 | Burst type, 2 bits per channel |
| ch_addr_o | output | 256 | Programmed address, 32 bits per channel |
| ch_count_o | output | 256 | Programmed count, 32 bits per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions matter most. The first is a status read that clear-on-read would erase while an engine's completion arrives in the same cycle. The second is a completion or bus error that lands on the same edge as a software write to that channel's control word. Directed cases drive the read strobe together with `eng_done_i`, and a lane-1 control write together with `eng_bus_err_i`. They then check that the new bit survives while the old bits were returned and cleared. Random cycles also set strobes, completions and errors together freely. A bench model applies the stated priority order (completion, then write, then error) and judges the read data, the pulses and the enable bits.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

  // packs onto control bits 10:0
  typedef struct packed {
    logic [1:0] burst;
    logic       berr;
    logic [3:0] ep;
    logic       ie;
    logic       mode1;
    logic       tx;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/dma_regbank_decode.sv
module dma_regbank_decode #(
  parameter int ADDR_W = 12,
  parameter int N_CH   = 8,
  parameter int BASE   = 'h200
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_stat_o,
  output logic [N_CH-1:0]   hit_ctrl_o,
  output logic [N_CH-1:0]   hit_addr_o,
  output logic [N_CH-1:0]   hit_cnt_o
);
  localparam int CH_W = $clog2(N_CH);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(N_CH * 16);

  logic [ADDR_W-1:0] rel;
  logic              in_win;
  logic [CH_W-1:0]   ch;
  logic [1:0]        word;

  // wrap-around subtract: one compare covers both window edges
  assign rel    = addr_i - BASE_A;
  assign in_win = rel < SPAN_A;
  assign ch     = rel[CH_W+3:4];
  assign word   = rel[3:2];

  assign hit_stat_o = in_win && (ch == '0) && (word == 2'd0);

  always_comb begin
    hit_ctrl_o = '0;
    hit_addr_o = '0;
    hit_cnt_o  = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (in_win && ch == CH_W'(c)) begin
        hit_ctrl_o[c] = (word == 2'd1);
        hit_addr_o[c] = (word == 2'd2);
        hit_cnt_o[c]  = (word == 2'd3);
      end
    end
  end
endmodule

// File: rtl/dma_regbank_chan.sv
module dma_regbank_chan
  import dma_regbank_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_ctrl_i,
  input  logic        we_addr_i,
  input  logic        we_cnt_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  input  logic        done_i,
  input  logic        err_i,
  output ctrl_t       ctrl_o,
  output logic [31:0] addr_o,
  output logic [31:0] cnt_o,
  output logic        start_o,
  output logic        abort_o
);
  ctrl_t       ctrl_q, ctrl_d;
  logic [31:0] addr_q, cnt_q;
  logic        start_q, abort_q;
  logic        wr_lo, wr_hi;

  assign wr_lo = we_ctrl_i & be_i[0];
  assign wr_hi = we_ctrl_i & be_i[1];

  // priority: completion < software write < bus error
  always_comb begin
    ctrl_d = ctrl_q;
    if (done_i) ctrl_d.en = 1'b0;
    if (wr_lo) begin
      ctrl_d.en    = wdata_i[0];
      ctrl_d.tx    = wdata_i[1];
      ctrl_d.mode1 = wdata_i[2];
      ctrl_d.ie    = wdata_i[3];
      ctrl_d.ep    = wdata_i[7:4];
    end
    if (wr_hi) begin
      ctrl_d.burst = wdata_i[10:9];
      ctrl_d.berr  = 1'b0;
    end
    if (err_i) ctrl_d.berr = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= wr_lo & wdata_i[0];
      abort_q <= wr_lo & ~wdata_i[0] & ctrl_q.en;
      if (we_addr_i) addr_q <= be_merge(addr_q, wdata_i, be_i);
      if (we_cnt_i)  cnt_q  <= be_merge(cnt_q, wdata_i, be_i);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
  assign start_o = start_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/dma_regbank_irq.sv
module dma_regbank_irq #(
  parameter int N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_clr_i,
  input  logic [N_CH-1:0] done_i,
  input  logic [N_CH-1:0] ie_i,
  output logic [N_CH-1:0] stat_o,
  output logic            irq_o
);
  logic [N_CH-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (rd_clr_i ? '0 : stat_q) | done_i;  // late completion survives the clear
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ie_i);
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int N_CH   = 8,      // at most 8: status lives in one byte
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic                 bus_re_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  input  logic [3:0]           bus_be_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [N_CH-1:0]      eng_done_i,
  input  logic [N_CH-1:0]      eng_bus_err_i,
  input  logic [32*N_CH-1:0]   eng_cur_addr_i,
  input  logic [32*N_CH-1:0]   eng_rem_count_i,
  output logic [N_CH-1:0]      ch_start_o,
  output logic [N_CH-1:0]      ch_abort_o,
  output logic [N_CH-1:0]      ch_en_o,
  output logic [N_CH-1:0]      ch_tx_o,
  output logic [N_CH-1:0]      ch_mode1_o,
  output logic [4*N_CH-1:0]    ch_ep_o,
  output logic [2*N_CH-1:0]    ch_burst_o,
  output logic [32*N_CH-1:0]   ch_addr_o,
  output logic [32*N_CH-1:0]   ch_count_o,
  output logic                 irq_o
);
  logic            hit_stat;
  logic [N_CH-1:0] hit_ctrl, hit_addr, hit_cnt;
  ctrl_t           ctrl_w [N_CH];
  logic [N_CH-1:0] ie_w, stat_w;
  logic [31:0]     rd_mux, rdata_q;

  dma_regbank_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH), .BASE(BASE)) u_decode (
    .addr_i     (bus_addr_i),
    .hit_stat_o (hit_stat),
    .hit_ctrl_o (hit_ctrl),
    .hit_addr_o (hit_addr),
    .hit_cnt_o  (hit_cnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_regbank_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_ctrl_i (bus_we_i & hit_ctrl[c]),
      .we_addr_i (bus_we_i & hit_addr[c]),
      .we_cnt_i  (bus_we_i & hit_cnt[c]),
      .be_i      (bus_be_i),
      .wdata_i   (bus_wdata_i),
      .done_i    (eng_done_i[c]),
      .err_i     (eng_bus_err_i[c]),
      .ctrl_o    (ctrl_w[c]),
      .addr_o    (ch_addr_o[32*c +: 32]),
      .cnt_o     (ch_count_o[32*c +: 32]),
      .start_o   (ch_start_o[c]),
      .abort_o   (ch_abort_o[c])
    );
    assign ch_en_o[c]           = ctrl_w[c].en;
    assign ch_tx_o[c]           = ctrl_w[c].tx;
    assign ch_mode1_o[c]        = ctrl_w[c].mode1;
    assign ch_ep_o[4*c +: 4]    = ctrl_w[c].ep;
    assign ch_burst_o[2*c +: 2] = ctrl_w[c].burst;
    assign ie_w[c]              = ctrl_w[c].ie;
  end

  dma_regbank_irq #(.N_CH(N_CH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_clr_i (bus_re_i & hit_stat),
    .done_i   (eng_done_i),
    .ie_i     (ie_w),
    .stat_o   (stat_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_stat) rd_mux[N_CH-1:0] = stat_w;
    for (int c = 0; c < N_CH; c++) begin
      if (hit_ctrl[c]) rd_mux[CTRL_W-1:0] = ctrl_w[c];
      if (hit_addr[c]) rd_mux = eng_cur_addr_i[32*c +: 32];
      if (hit_cnt[c])  rd_mux = eng_rem_count_i[32*c +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= bus_re_i ? rd_mux : '0;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_re_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic [N_CH-1:0]   eng_done_i,
  input logic [N_CH-1:0]   ch_start_o,
  input logic [N_CH-1:0]   ch_abort_o,
  input logic [N_CH-1:0]   ch_en_o,
  input logic [N_CH-1:0]   stat_i,
  input logic              irq_o
);
  localparam logic [ADDR_W:0] LO_A = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI_A = (ADDR_W+1)'(BASE + 16 * N_CH);

  logic unmapped;
  assign unmapped = ({1'b0, bus_addr_i} < LO_A) || ({1'b0, bus_addr_i} >= HI_A);

  assert_idle_rdata_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> bus_rdata_o == 32'd0);

  assert_unmapped_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && unmapped) |=> bus_rdata_o == 32'd0);

  assert_irq_needs_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0) |-> !irq_o);

  for (genvar c = 0; c < N_CH; c++) begin : g_prop
    assert_start_sets_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_start_o[c] |-> ch_en_o[c]);

    assert_abort_clears_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_abort_o[c] |-> !ch_en_o[c]);

    assert_start_abort_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ch_start_o[c] && ch_abort_o[c]));

    assert_done_kept_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_done_i[c] |=> stat_i[c]);
  end
endmodule

bind dma_regbank dma_regbank_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_re_i    (bus_re_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .eng_done_i  (eng_done_i),
  .ch_start_o  (ch_start_o),
  .ch_abort_o  (ch_abort_o),
  .ch_en_o     (ch_en_o),
  .stat_i      (stat_w),
  .irq_o       (irq_o)
);

// File: tb/dma_regbank_bench.sv
module dma_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_we_i = 1'b0, bus_re_i = 1'b0;
  logic [11:0]   bus_addr_i = '0;
  logic [31:0]   bus_wdata_i = '0;
  logic [3:0]    bus_be_i = '0;
  logic [31:0]   bus_rdata_o;
  logic [7:0]    eng_done_i = '0, eng_bus_err_i = '0;
  logic [255:0]  eng_cur_addr_i, eng_rem_count_i;
  logic [7:0]    ch_start_o, ch_abort_o, ch_en_o, ch_tx_o, ch_mode1_o;
  logic [31:0]   ch_ep_o;
  logic [15:0]   ch_burst_o;
  logic [255:0]  ch_addr_o, ch_count_o;
  logic          irq_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [10:0] m_ctrl [N_CH];
  logic [31:0] m_addr [N_CH], m_cnt [N_CH], live_addr [N_CH], live_cnt [N_CH];
  logic [7:0]  m_stat;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      eng_cur_addr_i[32*c +: 32]  = live_addr[c];
      eng_rem_count_i[32*c +: 32] = live_cnt[c];
    end
  end

  dma_regbank u_dma_regbank (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_expect(input logic [11:0] a);
    logic [11:0] rel;
    logic [2:0]  c;
    rel = a - 12'h200;
    c = rel[6:4];
    m_expect = '0;
    if (rel < 12'h080) begin
      case (rel[3:2])
        2'd0: if (c == 3'd0) m_expect = {24'd0, m_stat};
        2'd1: m_expect = {21'd0, m_ctrl[c]};
        2'd2: m_expect = live_addr[c];
        default: m_expect = live_cnt[c];
      endcase
    end
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    logic [11:0] rel;
    rel = a - 12'h200;
    if (rel >= 12'h080 || (rel[3:2] == 2'd0 && rel[6:4] != 3'd0)) return "R11 unmapped read";
    case (rel[3:2])
      2'd0: return "R9 status read";
      2'd1: return "R2 control read";
      default: return "R8 live read";
    endcase
  endfunction

  // one bus cycle; model order: completion, write, error, status clear
  task automatic bus_cycle(input logic we, input logic re, input logic [11:0] a,
                           input logic [31:0] d, input logic [3:0] be,
                           input logic [7:0] dn, input logic [7:0] er);
    logic [31:0] exp_rd;
    logic [7:0]  exp_st, exp_ab, exp_en;
    logic [11:0] rel;
    logic [2:0]  c;
    logic        hit;
    exp_rd = re ? m_expect(a) : 32'd0;
    rel = a - 12'h200;
    hit = rel < 12'h080;
    c = rel[6:4];
    exp_st = '0;
    exp_ab = '0;
    if (we && hit && rel[3:2] == 2'd1 && be[0]) begin
      exp_st[c] = d[0];
      exp_ab[c] = ~d[0] & m_ctrl[c][0];
    end
    for (int k = 0; k < N_CH; k++) if (dn[k]) m_ctrl[k][0] = 1'b0;
    if (we && hit) begin
      case (rel[3:2])
        2'd1: begin
          if (be[0]) m_ctrl[c][7:0] = d[7:0];
          if (be[1]) begin m_ctrl[c][10:9] = d[10:9]; m_ctrl[c][8] = 1'b0; end
        end
        2'd2: m_addr[c] = merge(m_addr[c], d, be);
        2'd3: m_cnt[c] = merge(m_cnt[c], d, be);
        default: ;
      endcase
    end
    for (int k = 0; k < N_CH; k++) if (er[k]) m_ctrl[k][8] = 1'b1;
    if (re && hit && rel[3:2] == 2'd0 && c == 3'd0) m_stat = '0;
    m_stat = m_stat | dn;
    bus_we_i = we; bus_re_i = re; bus_addr_i = a; bus_wdata_i = d; bus_be_i = be;
    eng_done_i = dn; eng_bus_err_i = er;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_re_i = 1'b0; bus_be_i = '0; eng_done_i = '0; eng_bus_err_i = '0;
    if (re) chk(rd_tag(a), bus_rdata_o, exp_rd);
    chk("R4 start pulses", {24'd0, ch_start_o}, {24'd0, exp_st});
    chk("R5 abort pulses", {24'd0, ch_abort_o}, {24'd0, exp_ab});
    for (int k = 0; k < N_CH; k++) exp_en[k] = m_ctrl[k][0];
    chk("R6 enable bits", {24'd0, ch_en_o}, {24'd0, exp_en});
    chk("R10 irq", {31'd0, irq_o}, {31'd0, |(m_stat & {m_ctrl[7][3], m_ctrl[6][3], m_ctrl[5][3],
        m_ctrl[4][3], m_ctrl[3][3], m_ctrl[2][3], m_ctrl[1][3], m_ctrl[0][3]})});
    if (we && hit && rel[3:2] == 2'd2) chk("R3 address out", ch_addr_o[32*c +: 32], m_addr[c]);
    if (we && hit && rel[3:2] == 2'd3) chk("R3 count out", ch_count_o[32*c +: 32], m_cnt[c]);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_cycle(1'b1, 1'b0, a, d, be, 8'd0, 8'd0);
  endtask

  task automatic rd(input logic [11:0] a);
    bus_cycle(1'b0, 1'b1, a, 32'd0, 4'd0, 8'd0, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < N_CH; c++) begin
      m_ctrl[c] = '0; m_addr[c] = '0; m_cnt[c] = '0;
      live_addr[c] = $urandom; live_cnt[c] = $urandom;
    end
    m_stat = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state
    chk("R12 enable after reset", {24'd0, ch_en_o}, 32'd0);
    chk("R12 rdata after reset", bus_rdata_o, 32'd0);
    chk("R12 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R12 address out after reset", ch_addr_o[31:0], 32'd0);

    // R3 byte-lane address and count writes
    wr(12'h228, 32'h1000_0040, 4'hF);
    wr(12'h22C, 32'hFFFF_0200, 4'b0011);
    wr(12'h228, 32'hFFFF_FFFF, 4'b0100);
    chk("R3 partial lane", ch_addr_o[64 +: 32], 32'h10FF_0040);

    // R2 R4 control fields and start
    wr(12'h224, 32'h0000_065F, 4'b0011);
    chk("R2 endpoint", {28'd0, ch_ep_o[8 +: 4]}, 32'd5);
    chk("R2 burst", {30'd0, ch_burst_o[4 +: 2]}, 32'd3);
    chk("R2 tx mode1", {30'd0, ch_tx_o[2], ch_mode1_o[2]}, 32'd3);
    @(negedge clk_i);
    chk("R4 start one cycle", {24'd0, ch_start_o}, 32'd0);
    rd(12'h224);
    rd(12'h22A);                          // R1 low address bits ignored, R8 live address

    // R6 R9 R10 completion, clear on read
    bus_cycle(1'b0, 1'b0, 12'h0, 32'd0, 4'd0, 8'h04, 8'd0);
    chk("R10 irq on completion", {31'd0, irq_o}, 32'd1);
    rd(12'h224);
    rd(12'h200);
    rd(12'h200);

    // R9 completion in the same cycle as the status read
    wr(12'h254, 32'h0000_0008, 4'b0001);
    wr(12'h214, 32'h0000_0008, 4'b0001);
    bus_cycle(1'b0, 1'b0, 12'h0, 32'd0, 4'd0, 8'h20, 8'd0);
    bus_cycle(1'b0, 1'b1, 12'h200, 32'd0, 4'd0, 8'h02, 8'd0);
    chk("R9 late completion pending", {31'd0, irq_o}, 32'd1);
    rd(12'h200);

    // R7 sticky bus error
    bus_cycle(1'b0, 1'b0, 12'h0, 32'd0, 4'd0, 8'd0, 8'h08);
    wr(12'h234, 32'h0000_0001, 4'b0001);
    rd(12'h234);
    chk("R7 error kept by lane-0 write", {31'd0, bus_rdata_o[8]}, 32'd1);
    bus_cycle(1'b1, 1'b0, 12'h234, 32'h0000_0100, 4'b0010, 8'd0, 8'h08);
    rd(12'h234);
    chk("R7 error wins over clear", {31'd0, bus_rdata_o[8]}, 32'd1);
    wr(12'h234, 32'h0000_0100, 4'b0010);
    rd(12'h234);
    chk("R7 cleared, not settable", {31'd0, bus_rdata_o[8]}, 32'd0);

    // R5 abort and zeroing
    wr(12'h224, 32'h0000_0001, 4'b0001);
    wr(12'h224, 32'h0000_0000, 4'b0011);
    chk("R5 abort seen", {31'd0, ch_abort_o[2]}, 32'd1);
    wr(12'h228, 32'd0, 4'hF);
    wr(12'h22C, 32'd0, 4'hF);
    chk("R5 address zeroed", ch_addr_o[64 +: 32], 32'd0);

    // R11 unmapped accesses
    wr(12'h1F8, 32'hFFFF_FFFF, 4'hF);
    wr(12'h210, 32'hFFFF_FFFF, 4'hF);
    wr(12'h200, 32'h0000_00FF, 4'hF);
    rd(12'h1F8);
    rd(12'h280);
    rd(12'h210);
    rd(12'h200);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [7:0] dn, er;
      if ($urandom % 8 == 0) a = ($urandom % 2 == 0) ? 12'(12'h1C0 + $urandom % 64) : 12'(12'h280 + $urandom % 64);
      else a = 12'(12'h200 + ($urandom % 8) * 16 + ($urandom % 4) * 4 + $urandom % 4);
      dn = ($urandom % 5 == 0) ? 8'($urandom) : 8'd0;
      er = ($urandom % 9 == 0) ? 8'($urandom) : 8'd0;
      if ($urandom % 16 == 0) live_addr[$urandom % 8] = $urandom;
      if ($urandom % 16 == 0) live_cnt[$urandom % 8] = $urandom;
      bus_cycle(1'($urandom), 1'($urandom), a, $urandom, 4'($urandom), dn, er);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule